// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the two low-order address bits that step through a four-beat memory burst. When the enclosing controller latches a new access, it pulses `load`. The block then captures the two low bits of that address as the burst seed and clears its beat index. On every later rising edge where the active-low advance input is low, the beat index moves up by one. The output address is a function of the seed and the beat index. A single counter serves both read and write bursts. The upper address bits bypass the block.

Two orderings come from the same counter. With `mode` low the burst is linear: the seed plus the beat index, modulo four. With `mode` high the burst is interleaved: the seed XOR the beat index. On a board the select pin may be left open, and an open pin reads as interleaved. The parameter `MODE_PIN_OPEN` models that case by ignoring the port and fixing interleaved order. After the fourth beat, one more advance wraps the address back to the seed.

Top module: `burst_seq_gen`

## Requirements
- R1: After reset, `beat` is 0 and `burst_addr` is 2'b00.
- R2: A rising edge with `load` high captures `seed` and clears `beat` to 0. From that edge on, `burst_addr` equals the captured seed.
- R3: When `load` and an advance (`adv_n` low) fall on the same edge, the load wins: `beat` becomes 0, not 1.
- R4: A rising edge with `load` low and `adv_n` low increments `beat` by one, modulo 4.
- R5: A rising edge with `load` low and `adv_n` high leaves `beat` and `burst_addr` unchanged.
- R6: While `mode` is 0 (linear), `burst_addr` = (seed + beat) mod 4. For example, seed 01 runs 01,10,11,00 and seed 11 runs 11,00,01,10.
- R7: While `mode` is 1 (interleaved), `burst_addr` = seed XOR beat. For example, seed 01 runs 01,00,11,10 and seed 11 runs 11,10,01,00.
- R8: An advance after the fourth beat wraps `beat` to 0 and returns `burst_addr` to the seed.
- R9: The ordering follows the present level of `mode` without a clock edge. Changing `mode` mid-burst changes `burst_addr` combinationally, and `beat` is left alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Address strobe: capture seed, restart burst |
| seed | input | 2 | Low address bits of the newly loaded address |
| adv_n | input | 1 | Active-low advance to next beat |
| mode | input | 1 | 0 = linear order, 1 = interleaved order |
| burst_addr | output | 2 | Current low burst address bits |
| beat | output | 2 | Beat index within the burst (0..3) |

## Verification
The embedded properties assume only that `load`, `adv_n` and `mode` are at known levels at every sampled edge after reset. The property that ties an address change to a beat change also assumes that `mode` has not moved between two edges. The stimulus holds all inputs defined from time zero. It drives them only on falling edges. It toggles `mode` only within a single cycle in the mid-burst switch test, and the property's stable-mode guard covers that case. Each expected address is computed in the bench from the seed, the beat count and the mode, using modular addition or XOR as written in the requirements.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int unsigned BURST_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [BURST_BITS-1:0] seed,
   input  logic                  adv_n,
   output logic [BURST_BITS-1:0] seed_q,
   output logic [BURST_BITS-1:0] beat_q
);

   localparam logic [BURST_BITS-1:0] ONE  = BURST_BITS'(1);
   localparam logic [BURST_BITS-1:0] ZERO = '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seed_q <= ZERO;
         beat_q <= ZERO;
      end else if (load) begin
         seed_q <= seed;
         beat_q <= ZERO;
      end else if (!adv_n) begin
         beat_q <= beat_q + ONE;
      end
   end

   // R2: load captures the seed and restarts the beat index
   a_r2_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (beat_q == ZERO) && (seed_q == $past(seed)));

   // R3: load outranks a simultaneous advance
   a_r3_load_beats_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !adv_n) |=> (beat_q == ZERO));

   // R4: a plain advance steps by exactly one
   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv_n) |=> (beat_q == $past(beat_q) + ONE));

   // R5: no load and no advance keeps the state frozen
   a_r5_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && adv_n) |=> ($stable(beat_q) && $stable(seed_q)));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int unsigned BURST_BITS    = 2,
   parameter bit          MODE_PIN_OPEN = 1'b0
) (
   input  logic [BURST_BITS-1:0] seed_q,
   input  logic [BURST_BITS-1:0] beat_q,
   input  logic                  mode,
   output logic [BURST_BITS-1:0] addr
);

   burst_order_e                order;
   logic [BURST_BITS-1:0]       lin_addr;
   logic [BURST_BITS-1:0]       ilv_addr;

   // An open select pin is pulled toward interleaved order.
   assign order    = MODE_PIN_OPEN ? ORD_INTERLEAVE : burst_order_e'(mode);
   assign lin_addr = seed_q + beat_q;

   genvar gi;
   generate
      for (gi = 0; gi < BURST_BITS; gi++) begin : g_ilv_bit
         assign ilv_addr[gi] = seed_q[gi] ^ beat_q[gi];
      end
   endgenerate

   always_comb begin
      unique case (order)
         ORD_LINEAR:     addr = lin_addr;
         ORD_INTERLEAVE: addr = ilv_addr;
         default:        addr = ilv_addr;
      endcase
   end

endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen #(
   parameter int unsigned BURST_BITS    = 2,
   parameter bit          MODE_PIN_OPEN = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [BURST_BITS-1:0] seed,
   input  logic                  adv_n,
   input  logic                  mode,
   output logic [BURST_BITS-1:0] burst_addr,
   output logic [BURST_BITS-1:0] beat
);

   localparam int unsigned BEATS = 1 << BURST_BITS;

   generate
      if (BURST_BITS < 1 || BURST_BITS > 4) begin : g_bad_width
         initial begin
            assert (0) else $error("burst_seq_gen: BURST_BITS %0d outside 1..4", BURST_BITS);
         end
      end
   endgenerate

   initial begin
      assert (BEATS >= 2) else $error("burst_seq_gen: burst of %0d beats too short", BEATS);
   end

   logic [BURST_BITS-1:0] seed_q;
   logic [BURST_BITS-1:0] beat_q;

   burst_beat_ctr #(.BURST_BITS(BURST_BITS)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .seed   (seed),
      .adv_n  (adv_n),
      .seed_q (seed_q),
      .beat_q (beat_q)
   );

   burst_order_map #(
      .BURST_BITS   (BURST_BITS),
      .MODE_PIN_OPEN(MODE_PIN_OPEN)
   ) u_map (
      .seed_q (seed_q),
      .beat_q (beat_q),
      .mode   (mode),
      .addr   (burst_addr)
   );

   assign beat = beat_q;

   // R2, R8: beat zero always presents the seed, in either order
   a_r8_first_is_seed: assert property (@(posedge clk) disable iff (!rst_n)
      (beat == '0) |-> (burst_addr == seed_q));

   // R6, R7: both orderings visit distinct addresses on each step
   a_r6_step_moves_addr: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(load) && !$past(adv_n) && $stable(mode))
         |-> (burst_addr != $past(burst_addr)));

endmodule

// File: tb/sim_burst_seq_gen.sv
`timescale 1ns/1ps
module sim_burst_seq_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load = 1'b0;
   logic [1:0] seed = 2'b00;
   logic       adv_n = 1'b1;
   logic       mode = 1'b0;
   logic [1:0] burst_addr;
   logic [1:0] beat;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   burst_seq_gen u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .seed       (seed),
      .adv_n      (adv_n),
      .mode       (mode),
      .burst_addr (burst_addr),
      .beat       (beat)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int ord_addr(input int s, input int k, input bit m);
      return m ? ((s ^ k) & 3) : ((s + k) % 4);
   endfunction

   task automatic start_burst(input int s);
      @(negedge clk);
      load  = 1'b1;
      seed  = 2'(s);
      adv_n = 1'b1;
      @(negedge clk);
      load  = 1'b0;
   endtask

   task automatic test_reset;
      @(negedge clk);
      chk("R1 beat", beat, 0);
      chk("R1 addr", burst_addr, 0);
   endtask

   // R6 / R7 / R8: full burst from every seed, then one more advance wraps
   task automatic test_full_bursts(input bit m);
      mode = m;
      for (int s = 0; s < 4; s++) begin
         start_burst(s);
         chk("R2 addr=seed", burst_addr, s);
         chk("R2 beat=0", beat, 0);
         adv_n = 1'b0;
         for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            chk(m ? "R7 order" : "R6 order", burst_addr, ord_addr(s, k, m));
            chk("R4 beat", beat, k);
         end
         @(negedge clk);
         chk("R8 wrap addr", burst_addr, s);
         chk("R8 wrap beat", beat, 0);
         adv_n = 1'b1;
      end
   endtask

   task automatic test_hold;
      mode = 1'b0;
      start_burst(2);
      adv_n = 1'b0;
      @(negedge clk);
      adv_n = 1'b1;
      chk("R4 beat", beat, 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R5 hold beat", beat, 1);
         chk("R5 hold addr", burst_addr, 3);
      end
   endtask

   task automatic test_load_priority;
      mode = 1'b1;
      start_burst(1);
      adv_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R4 beat", beat, 2);
      load = 1'b1;
      seed = 2'd3;
      @(negedge clk);
      load  = 1'b0;
      adv_n = 1'b1;
      chk("R3 beat", beat, 0);
      chk("R3 addr", burst_addr, 3);
   endtask

   task automatic test_mode_switch;
      mode = 1'b0;
      start_burst(1);
      adv_n = 1'b0;
      @(negedge clk);
      adv_n = 1'b1;
      chk("R6 linear", burst_addr, 2);
      mode = 1'b1;
      #1;
      chk("R9 switch addr", burst_addr, 0);
      chk("R9 switch beat", beat, 1);
      mode = 1'b0;
      #1;
      chk("R9 back addr", burst_addr, 2);
   endtask

   task automatic finish_run;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 20000);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_full_bursts(1'b0);
      test_full_bursts(1'b1);
      test_hold();
      test_load_priority();
      test_mode_switch();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule